// File: doc/BRIEF.md
# Edge-Latched Fuse ROM With Synchronous Bus Interface

This block models a one-time-programmable read-only memory of 512 bytes that sits on a synchronous microprocessor bus. A read begins when the active-low chip enable falls: the nine-bit address is captured at that moment, so a multiplexed address/data bus may move on right away. When the chip enable rises again, the byte at the captured address is loaded into an output register. That register holds its value until the next rising enable. Three output-enable inputs decide whether the output register is driven onto the bus. Two of them are active-low and one is active-high.

The storage is a 64 x 64 fuse matrix. Address bits 8..3 pick a row, and bits 2..0 pick one of eight byte-wide column groups in that row. Every fuse starts at 0. A fuse can only ever be set to 1, through a programming port: with program mode on, the programmer holds exactly one data pin low for a fixed number of clock cycles. The chip-enable edges are sampled with the block clock. The tri-state bus is represented by a data output and a separate drive-enable output. A backdoor port lets a testbench load the array before use.

Top module: `fuse_rom_sync`

## Requirements
- R1: The array holds 512 bytes. A read returns the byte stored at the nine-bit address, and a location never written reads 0x00.
- R2: The address is sampled on the clock edge that first sees `ce_n` low after it was high. Changes on `addr` after that edge do not affect the byte returned.
- R3: `q_data` is loaded only on the clock edge that first sees `ce_n` high after it was low. At all other times it holds its value, including while `ce_n` stays low.
- R4: The array is organised so that address bits 8..3 select the row and bits 2..0 select the column group. Bit j of a word is column j of its group, so addresses that differ only in row bits or only in column bits are distinct words.
- R5: Fuses only change from 0 to 1. A backdoor load ORs its byte into the stored word, and programming a bit that is already 1 leaves the word unchanged.
- R6: `q_drive` is 1 exactly when `oe1_n`=0, `oe2_n`=0, `oe3`=1 and `pgm_en`=0. The change takes effect in the same cycle, independent of `ce_n`.
- R7: Reset clears `q_data` to 0x00, clears `pgm_err` and clears the sampled address. The fuse array keeps its contents through reset.
- R8: With `pgm_en`=1, holding exactly one pin j of `pgm_pins` low for PULSE_CYC consecutive clock edges sets bit j of the word at the latched address. A shorter pulse sets nothing.
- R9: With `pgm_en`=1, when more than one pin of `pgm_pins` is low, `pgm_err` is 1 on the following cycle and no fuse is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sampling clock for enable edges |
| rst_n | input | 1 | Active-low reset of latches (not the array) |
| ce_n | input | 1 | Active-low chip enable |
| addr | input | 9 | Word address |
| oe1_n | input | 1 | Output enable, active low |
| oe2_n | input | 1 | Output enable, active low |
| oe3 | input | 1 | Output enable, active high |
| pgm_en | input | 1 | Program mode select |
| pgm_pins | input | 8 | Data pins as driven by the programmer (low = program) |
| ld_we | input | 1 | Backdoor load strobe |
| ld_addr | input | 9 | Backdoor load address |
| ld_data | input | 8 | Backdoor load byte (ORed in) |
| q_data | output | 8 | Output data register |
| q_drive | output | 1 | Bus drive enable; 0 means high impedance |
| pgm_err | output | 1 | More than one programming pin low (registered) |

## Verification
The address is sampled on the first clock edge after `ce_n` is driven low. The read byte appears on `q_data` one register later, at the first edge after `ce_n` returns high. `q_drive` is combinational and follows the enables within the cycle. A programmed fuse is in place after the PULSE_CYC-th edge with a pin held low, and `pgm_err` rises one edge after a multi-pin pattern. All inputs are driven on falling clock edges, and every result is sampled at the next falling edge after the edge that produces it. Reads therefore sample two falling edges after the enable fall, and programming results are read back through a full read cycle.

// File: rtl/fuse_rom_sync.sv
module fuse_rom_sync #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int ROW_BITS  = 6,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic          oe1_n,
  input  logic          oe2_n,
  input  logic          oe3,
  input  logic          pgm_en,
  input  logic [DW-1:0] pgm_pins,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] q_data,
  output logic          q_drive,
  output logic          pgm_err
);
  localparam int CB   = AW - ROW_BITS;
  localparam int ROWS = 1 << ROW_BITS;
  localparam int ROWW = (1 << CB) * DW;
  localparam int BW   = $clog2(ROWW);
  localparam int PW   = $clog2(DW);
  localparam int CW   = $clog2(PULSE_CYC + 1);

  logic [ROWW-1:0] fuse [ROWS] = '{default: '0};
  logic            ce_q;
  logic [AW-1:0]   addr_r;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   pin_r;
  logic [PW-1:0]   pin_idx;
  logic            held, fire;

  wire ce_fall = ce_q & ~ce_n;
  wire ce_rise = ~ce_q & ce_n;
  wire [ROW_BITS-1:0] arow = addr_r[AW-1:CB];
  wire [ROWW-1:0]     row_q = fuse[arow];
  wire [BW-1:0]       rd_base = BW'(addr_r[CB-1:0]) * BW'(DW);
  wire [BW-1:0]       bpos = rd_base + BW'(pin_idx);
  wire [BW-1:0]       ld_base = BW'(ld_addr[CB-1:0]) * BW'(DW);

  always_comb begin
    pin_idx = '0;
    for (int i = DW - 1; i >= 0; i--)
      if (!pgm_pins[i]) pin_idx = PW'(i);
  end

  assign held    = pgm_en && ($countones(~pgm_pins) == 1);
  assign fire    = held && (cnt != '0) && (pin_r == pin_idx) && (cnt == CW'(PULSE_CYC - 1));
  assign q_drive = ~oe1_n & ~oe2_n & oe3 & ~pgm_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      addr_r  <= '0;
      q_data  <= '0;
      pgm_err <= 1'b0;
      cnt     <= '0;
      pin_r   <= '0;
    end else begin
      ce_q    <= ce_n;
      pgm_err <= pgm_en && ($countones(~pgm_pins) > 1);
      if (ce_fall) addr_r <= addr;
      if (ce_rise) q_data <= row_q[rd_base +: DW];
      if (!held) cnt <= '0;
      else if (cnt == '0 || pin_r != pin_idx) begin
        cnt   <= CW'(1);
        pin_r <= pin_idx;
      end else if (cnt != CW'(PULSE_CYC)) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we)
      fuse[ld_addr[AW-1:CB]] <= fuse[ld_addr[AW-1:CB]] | (ROWW'(ld_data) << ld_base);
    if (fire)
      fuse[arow][bpos] <= 1'b1;
  end

  p_addr_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !ce_n) |=> (addr_r == $past(addr)));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_q && ce_n) |=> $stable(q_data));

  p_fuse_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr_r) |-> ((fuse[arow] & $past(fuse[arow])) == $past(fuse[arow])));

  p_no_drive_in_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en || oe1_n || oe2_n || !oe3) |-> !q_drive);

  p_prog_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> fuse[$past(arow)][$past(bpos)]);

  p_multi_low_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en && $countones(~pgm_pins) > 1) |=> pgm_err);

  p_no_fire_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en && $countones(~pgm_pins) > 1) |-> !fire);

  initial assert (PULSE_CYC >= 2 && ROW_BITS < AW);
endmodule

// File: tb/sim_fuse_rom_sync.sv
module sim_fuse_rom_sync;
  localparam int PULSE = 4;
  logic clk = 0, rst_n = 0, ce_n = 1, oe1_n = 0, oe2_n = 0, oe3 = 1, pgm_en = 0, ld_we = 0;
  logic [8:0] addr = '0, ld_addr = '0;
  logic [7:0] pgm_pins = 8'hff, ld_data = '0;
  logic [7:0] q_data;
  logic q_drive, pgm_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  fuse_rom_sync #(.PULSE_CYC(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr), .oe1_n(oe1_n), .oe2_n(oe2_n),
    .oe3(oe3), .pgm_en(pgm_en), .pgm_pins(pgm_pins), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .q_data(q_data), .q_drive(q_drive), .pgm_err(pgm_err));

  // {address, expected byte}
  localparam logic [16:0] VEC [8] = '{
    {9'h000, 8'ha5}, {9'h001, 8'h3c}, {9'h008, 8'h0f}, {9'h1ff, 8'h81},
    {9'h100, 8'h7e}, {9'h0c7, 8'h55}, {9'h038, 8'hc3}, {9'h107, 8'h99}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); ld_we = 1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_we = 0;
  endtask

  // fall then rise of ce_n; q_data valid at the negedge after the rise edge
  task automatic rd(input logic [8:0] a);
    @(negedge clk); addr = a; ce_n = 0;
    @(negedge clk); addr = ~a; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] pins, input int n);
    @(negedge clk); pgm_pins = pins;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); pgm_pins = 8'hff;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R7 reset q_data", q_data, 8'h00);
    chk("R7 reset pgm_err", {7'd0, pgm_err}, 8'h00);
    rst_n = 1;

    for (int i = 0; i < 8; i++) preload(VEC[i][16:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][16:8]);
      chk("R1 R4 table read", q_data, VEC[i][7:0]);
    end
    rd(9'h002);
    chk("R1 unwritten reads zero", q_data, 8'h00);

    // R2: address moves right after the fall edge
    @(negedge clk); addr = 9'h1ff; ce_n = 0;
    @(negedge clk); addr = 9'h000;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    chk("R2 captured address", q_data, 8'h81);

    // R3: hold while ce_n low
    @(negedge clk); addr = 9'h100; ce_n = 0;
    repeat (3) @(negedge clk);
    chk("R3 hold during low", q_data, 8'h81);
    ce_n = 1;
    @(negedge clk);
    chk("R3 load on rise", q_data, 8'h7e);
    repeat (3) @(negedge clk);
    chk("R3 hold while high", q_data, 8'h7e);

    // R6: output gating
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); {pgm_en, oe1_n, oe2_n, oe3} = 4'(k);
      #1;
      chk("R6 drive enable", {7'd0, q_drive}, {7'd0, (k == 1)});
    end
    @(negedge clk); {pgm_en, oe1_n, oe2_n, oe3} = 4'b0001;

    // R5: backdoor OR cannot clear
    preload(9'h001, 8'h00);
    rd(9'h001);
    chk("R5 no clear by load", q_data, 8'h3c);

    // R8: full pulse on 0x0aa pin 5
    @(negedge clk); pgm_en = 1;
    rd(9'h0aa);
    pulse(8'hdf, PULSE);
    @(negedge clk); pgm_en = 0;
    rd(9'h0aa);
    chk("R8 bit programmed", q_data, 8'h20);

    // R8: short pulse on 0x0ab pin 2
    @(negedge clk); pgm_en = 1;
    rd(9'h0ab);
    pulse(8'hfb, PULSE - 1);
    @(negedge clk); pgm_en = 0;
    rd(9'h0ab);
    chk("R8 short pulse no effect", q_data, 8'h00);

    // R5: reprogram set bit, then new bit, on 0x000
    @(negedge clk); pgm_en = 1;
    rd(9'h000);
    pulse(8'hfe, PULSE);
    pulse(8'hfd, PULSE);
    @(negedge clk); pgm_en = 0;
    rd(9'h000);
    chk("R5 R8 monotonic program", q_data, 8'ha7);

    // R9: two pins low
    @(negedge clk); pgm_en = 1;
    rd(9'h0ac);
    @(negedge clk); pgm_pins = 8'hf3;
    @(negedge clk);
    chk("R9 error flag", {7'd0, pgm_err}, 8'h01);
    repeat (PULSE + 2) @(negedge clk);
    pgm_pins = 8'hff;
    @(negedge clk);
    chk("R9 error clears", {7'd0, pgm_err}, 8'h00);
    pgm_en = 0;
    rd(9'h0ac);
    chk("R9 nothing programmed", q_data, 8'h00);

    // R7: reset keeps array
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R7 reset clears q_data", q_data, 8'h00);
    rst_n = 1;
    rd(9'h1ff);
    chk("R7 array kept", q_data, 8'h81);
    rd(9'h0aa);
    chk("R7 programmed kept", q_data, 8'h20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule